// File: doc/BRIEF.md
# Shared Page Relocation Sequencer

This block sits inside the central shared-memory manager and relocates a run of consecutive shared pages into a destination memory module. A command names an operation (relocate or duplicate), a module selector, a starting virtual page and a page count. The sequencer first asks the page allocator for destination space. The allocator also resolves the physical base of the source run and, for a duplicate, the new virtual page. The sequencer then streams the data one word at a time, with a read cycle followed by a write cycle. The word offset covers the whole page before the page index moves on.

A relocate keeps the software-visible virtual address. After allocation it broadcasts one translation-invalidate per page, so cached translations drop out. It then copies the data. At the end it releases each source page and rewrites the page-table entry to the new physical page. From command acceptance until the response, any access that names a page of the run is held with no answer. A duplicate leaves the source alone and returns the freshly assigned virtual page. A selector value of zero lets the sequencer pick the module itself in rotating order. Only one command runs at a time.

Top module: `spm_top`

## Requirements
- R1: After reset, `busy`, `alloc_req`, `inv_valid`, `mem_rd_en`, `mem_wr_en`, `free_valid`, `pt_upd_valid` and `rsp_valid` are all low.
- R2: A command with a non-zero count is accepted when idle. The next cycle raises `alloc_req` with `alloc_npages` equal to the count and `alloc_mod` equal to a non-zero `cmd_mod`.
- R3: Selector 0 means automatic choice. Automatic commands with a non-zero count get modules 1, 2, …, NUM_MOD, 1, … in turn. Explicit selectors and zero-count commands do not advance the rotation.
- R4: `cmd_move`=1 selects relocate. After a successful allocation, `inv_valid` pulses once per page, one cycle each, with `inv_vpn` = start+0, +1, …, and all of them come before the first memory write.
- R5: Word w of page p is read at address {src_ppn+p, w}, with the word offset in the low log2(PAGE_WORDS) bits. The read data, which arrives one cycle later, is written at {dst_ppn+p, w} in the cycle after the read. Every word of every page is copied.
- R6: At the end of a relocate, one cycle per page p raises `free_valid` with `free_ppn`=src_ppn+p, together with `pt_upd_valid`, `pt_upd_vpn`=start+p and `pt_upd_ppn`=dst_ppn+p. The response carries `rsp_ok`=1 and `rsp_vpn`= the start page.
- R7: A duplicate (`cmd_move`=0) raises no invalidate, free or table update. Its response carries `rsp_ok`=1 and `rsp_vpn`=`alloc_dst_vpn`.
- R8: If the allocator answers with `alloc_ok`=0, the response follows in the next cycle with `rsp_ok`=0 and `rsp_vpn`=0. No invalidate is sent and no memory write happens.
- R9: `busy` is high from acceptance through the response cycle. A command presented while busy is ignored: no second allocation, no change of result, no extra response.
- R10: During a relocate, `acc_hold` is high when `acc_req` is high and `acc_vpn` lies inside the run. It is low for pages outside the run and at any time during a duplicate.
- R11: A zero-count command gets an invalid response (`rsp_ok`=0) in the cycle after acceptance, with no allocation request.
- R12: With an allocator that answers in the cycle it is asked, `rsp_valid` rises 2+2·N·PAGE_WORDS clock edges after acceptance for a duplicate and 2+2N+2·N·PAGE_WORDS for a relocate (N pages). A failed allocation gives 2 and a zero count gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_move | input | 1 | 1 = relocate, 0 = duplicate |
| cmd_mod | input | MOD_W | Destination module, 0 = automatic |
| cmd_vpn | input | VPN_W | First virtual page |
| cmd_npages | input | CNT_W | Number of pages |
| busy | output | 1 | Command in progress |
| alloc_req | output | 1 | Allocation request, held until answered |
| alloc_mod | output | MOD_W | Chosen destination module |
| alloc_npages | output | CNT_W | Pages to allocate |
| alloc_done | input | 1 | Allocator answer strobe |
| alloc_ok | input | 1 | Allocation succeeded |
| alloc_src_ppn | input | PPN_W | Physical base of the source run |
| alloc_dst_ppn | input | PPN_W | Physical base of the destination run |
| alloc_dst_vpn | input | VPN_W | Virtual base assigned to the duplicate |
| inv_valid | output | 1 | Translation-invalidate broadcast |
| inv_vpn | output | VPN_W | Page to invalidate |
| mem_rd_en | output | 1 | Shared memory read |
| mem_rd_addr | output | PPN_W+log2(PAGE_WORDS) | Read word address |
| mem_rd_data | input | DATA_W | Read data, one cycle after the read |
| mem_wr_en | output | 1 | Shared memory write |
| mem_wr_addr | output | PPN_W+log2(PAGE_WORDS) | Write word address |
| mem_wr_data | output | DATA_W | Write data |
| free_valid | output | 1 | Release a source page |
| free_ppn | output | PPN_W | Page released |
| pt_upd_valid | output | 1 | Page-table rewrite |
| pt_upd_vpn | output | VPN_W | Virtual page rewritten |
| pt_upd_ppn | output | PPN_W | New physical page |
| acc_req | input | 1 | Access lookup presented to the manager |
| acc_vpn | input | VPN_W | Page of that access |
| acc_hold | output | 1 | Access must wait for the relocate to end |
| rsp_valid | output | 1 | Completion strobe |
| rsp_ok | output | 1 | 1 = done, 0 = invalid |
| rsp_vpn | output | VPN_W | Resulting virtual page |

## Verification
A corrupted word or page counter shows up at the memory ports: the bench would see a wrong read or write address in the same cycle, and a wrong destination word once the command has finished. A wrong state-machine step shifts the response edge relative to the exact cycle count the bench predicts. It can also put a write ahead of the last invalidate, or emit a release or table rewrite during a duplicate, and each of these is visible within the faulty cycle. A corrupted rotation pointer gives the wrong module on the next automatic allocation request.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ALLOC = 3'd1,
    S_INV   = 3'd2,
    S_RD    = 3'd3,
    S_WR    = 3'd4,
    S_FIN   = 3'd5,
    S_RSP   = 3'd6
  } spm_state_e;
endpackage

// File: rtl/spm_dest_pick.sv
module spm_dest_pick #(
  parameter int NUM_MOD = 3,
  parameter int MOD_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [MOD_W-1:0] sel_in,
  output logic [MOD_W-1:0] dest_out
);
  logic [MOD_W-1:0] ptr_q, ptr_d;
  logic             auto_sel;
  logic             ptr_en;

  assign auto_sel = (sel_in == '0);
  assign dest_out = auto_sel ? ptr_q : sel_in;
  assign ptr_en   = take && auto_sel;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_en) begin
      ptr_d = (ptr_q == MOD_W'(NUM_MOD)) ? MOD_W'(1) : ptr_q + MOD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= MOD_W'(1);
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // R3: the rotation pointer always names a real module
  a_r3_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q != '0) && (ptr_q <= MOD_W'(NUM_MOD)));
endmodule

// File: rtl/spm_walk.sv
module spm_walk #(
  parameter int PAGE_WORDS = 1024,
  parameter int CNT_W      = 4,
  localparam int OFF_W     = $clog2(PAGE_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wstep,
  input  logic             pstep,
  input  logic [CNT_W-1:0] npages,
  output logic [OFF_W-1:0] word,
  output logic [CNT_W-1:0] page,
  output logic             last_word,
  output logic             last_page
);
  logic [OFF_W-1:0] word_d;
  logic [CNT_W-1:0] page_d;
  logic             en;

  assign last_word = (word == OFF_W'(PAGE_WORDS - 1));
  assign last_page = (page == npages - CNT_W'(1));
  assign en        = clr || wstep || pstep;

  always_comb begin
    word_d = word;
    page_d = page;
    if (clr) begin
      word_d = '0;
      page_d = '0;
    end else if (pstep) begin
      word_d = '0;
      page_d = page + CNT_W'(1);
    end else if (wstep) begin
      if (last_word) begin
        word_d = '0;
        page_d = page + CNT_W'(1);
      end else begin
        word_d = word + OFF_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      page <= '0;
    end else if (en) begin
      word <= word_d;
      page <= page_d;
    end
  end

  // R5: the page index never steps past the last page of the run
  a_r5_no_page_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (wstep && !clr && last_word && last_page) |-> 1'b0);
endmodule

// File: rtl/spm_top.sv
module spm_top
  import spm_pkg::*;
#(
  parameter int NUM_MOD    = 3,
  parameter int MOD_W      = 2,
  parameter int VPN_W      = 12,
  parameter int PPN_W      = 10,
  parameter int CNT_W      = 4,
  parameter int PAGE_WORDS = 1024,
  parameter int DATA_W     = 32,
  localparam int OFF_W     = $clog2(PAGE_WORDS),
  localparam int ADDR_W    = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_move,
  input  logic [MOD_W-1:0]  cmd_mod,
  input  logic [VPN_W-1:0]  cmd_vpn,
  input  logic [CNT_W-1:0]  cmd_npages,
  output logic              busy,
  output logic              alloc_req,
  output logic [MOD_W-1:0]  alloc_mod,
  output logic [CNT_W-1:0]  alloc_npages,
  input  logic              alloc_done,
  input  logic              alloc_ok,
  input  logic [PPN_W-1:0]  alloc_src_ppn,
  input  logic [PPN_W-1:0]  alloc_dst_ppn,
  input  logic [VPN_W-1:0]  alloc_dst_vpn,
  output logic              inv_valid,
  output logic [VPN_W-1:0]  inv_vpn,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              free_valid,
  output logic [PPN_W-1:0]  free_ppn,
  output logic              pt_upd_valid,
  output logic [VPN_W-1:0]  pt_upd_vpn,
  output logic [PPN_W-1:0]  pt_upd_ppn,
  input  logic              acc_req,
  input  logic [VPN_W-1:0]  acc_vpn,
  output logic              acc_hold,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [VPN_W-1:0]  rsp_vpn
);
  spm_state_e st_q, st_d;

  logic             r_move, r_ok;
  logic [MOD_W-1:0] r_mod;
  logic [VPN_W-1:0] r_vpn, r_dvpn;
  logic [CNT_W-1:0] r_n;
  logic [PPN_W-1:0] r_src, r_dst;

  logic take_cmd, take_alloc, ok_en, ok_d;
  logic w_clr, w_step, p_step;
  logic [MOD_W-1:0] dest_sel;
  logic [OFF_W-1:0] word;
  logic [CNT_W-1:0] page;
  logic last_word, last_page;
  logic [PPN_W-1:0] src_cur, dst_cur;
  logic [VPN_W-1:0] vpn_cur, acc_off;
  logic in_flight;

  spm_dest_pick #(.NUM_MOD(NUM_MOD), .MOD_W(MOD_W)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .take(take_cmd && (cmd_npages != '0)),
    .sel_in(cmd_mod), .dest_out(dest_sel)
  );

  spm_walk #(.PAGE_WORDS(PAGE_WORDS), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .clr(w_clr), .wstep(w_step), .pstep(p_step),
    .npages(r_n), .word(word), .page(page),
    .last_word(last_word), .last_page(last_page)
  );

  always_comb begin
    st_d = st_q; take_cmd = 1'b0; take_alloc = 1'b0;
    ok_en = 1'b0; ok_d = 1'b0;
    w_clr = 1'b0; w_step = 1'b0; p_step = 1'b0;
    case (st_q)
      S_IDLE: if (cmd_valid) begin
        take_cmd = 1'b1; w_clr = 1'b1;
        if (cmd_npages == '0) begin st_d = S_RSP; ok_en = 1'b1; end
        else st_d = S_ALLOC;
      end
      S_ALLOC: if (alloc_done) begin
        w_clr = 1'b1;
        if (!alloc_ok) begin st_d = S_RSP; ok_en = 1'b1; end
        else begin take_alloc = 1'b1; st_d = r_move ? S_INV : S_RD; end
      end
      S_INV: if (last_page) begin w_clr = 1'b1; st_d = S_RD; end
             else p_step = 1'b1;
      S_RD: st_d = S_WR;
      S_WR: if (last_word && last_page) begin
        w_clr = 1'b1;
        if (r_move) st_d = S_FIN;
        else begin st_d = S_RSP; ok_en = 1'b1; ok_d = 1'b1; end
      end else begin
        w_step = 1'b1; st_d = S_RD;
      end
      S_FIN: if (last_page) begin st_d = S_RSP; ok_en = 1'b1; ok_d = 1'b1; end
             else p_step = 1'b1;
      S_RSP: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; r_move <= 1'b0; r_mod <= '0; r_vpn <= '0; r_n <= '0;
      r_src <= '0; r_dst <= '0; r_dvpn <= '0; r_ok <= 1'b0;
    end else begin
      st_q <= st_d;
      if (take_cmd) begin
        r_move <= cmd_move; r_mod <= dest_sel; r_vpn <= cmd_vpn; r_n <= cmd_npages;
      end
      if (take_alloc) begin
        r_src <= alloc_src_ppn; r_dst <= alloc_dst_ppn; r_dvpn <= alloc_dst_vpn;
      end
      if (ok_en) r_ok <= ok_d;
    end
  end

  assign src_cur   = r_src + PPN_W'(page);
  assign dst_cur   = r_dst + PPN_W'(page);
  assign vpn_cur   = r_vpn + VPN_W'(page);
  assign in_flight = (st_q != S_IDLE) && (st_q != S_RSP);
  assign acc_off   = acc_vpn - r_vpn;

  assign busy         = (st_q != S_IDLE);
  assign alloc_req    = (st_q == S_ALLOC);
  assign alloc_mod    = r_mod;
  assign alloc_npages = r_n;
  assign inv_valid    = (st_q == S_INV);
  assign inv_vpn      = vpn_cur;
  assign mem_rd_en    = (st_q == S_RD);
  assign mem_rd_addr  = {src_cur, word};
  assign mem_wr_en    = (st_q == S_WR);
  assign mem_wr_addr  = {dst_cur, word};
  assign mem_wr_data  = mem_rd_data;
  assign free_valid   = (st_q == S_FIN);
  assign free_ppn     = src_cur;
  assign pt_upd_valid = (st_q == S_FIN);
  assign pt_upd_vpn   = vpn_cur;
  assign pt_upd_ppn   = dst_cur;
  assign acc_hold     = acc_req && r_move && in_flight && (acc_off < VPN_W'(r_n));
  assign rsp_valid    = (st_q == S_RSP);
  assign rsp_ok       = r_ok;
  assign rsp_vpn      = r_ok ? (r_move ? r_vpn : r_dvpn) : '0;

  // tracks whether any write happened since the last acceptance
  logic wr_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_seen <= 1'b0;
    else if (take_cmd) wr_seen <= 1'b0;
    else if (mem_wr_en) wr_seen <= 1'b1;
  end

  // R8: a failed command has written nothing
  a_r8_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> !wr_seen);
  // R5: each write directly follows its read
  a_r5_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en));
  // R9: the response closes the command
  a_r9_rsp_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !busy && !rsp_valid);
  // R10: holding only happens while a command runs
  a_r10_hold_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hold |-> busy && !rsp_valid);
  // R2: the allocator is only ever asked for a real module
  a_r2_alloc_mod_real: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |-> (alloc_mod != '0) && (alloc_mod <= MOD_W'(NUM_MOD)) && (alloc_npages != '0));
endmodule

// File: tb/spm_top_tb.sv
module spm_top_tb;
  localparam int NUM_MOD = 3, MOD_W = 2, VPN_W = 6, PPN_W = 4, CNT_W = 3;
  localparam int PW = 4, DATA_W = 16, ADDR_W = PPN_W + 2, MEMSZ = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic cmd_valid, cmd_move; logic [MOD_W-1:0] cmd_mod;
  logic [VPN_W-1:0] cmd_vpn; logic [CNT_W-1:0] cmd_npages;
  logic busy, alloc_req; logic [MOD_W-1:0] alloc_mod; logic [CNT_W-1:0] alloc_npages;
  logic b_ok; logic [PPN_W-1:0] b_src, b_dst; logic [VPN_W-1:0] b_dvpn;
  logic inv_valid; logic [VPN_W-1:0] inv_vpn;
  logic mem_rd_en, mem_wr_en; logic [ADDR_W-1:0] mem_rd_addr, mem_wr_addr;
  logic [DATA_W-1:0] mem_rd_data, mem_wr_data;
  logic free_valid, pt_upd_valid; logic [PPN_W-1:0] free_ppn, pt_upd_ppn;
  logic [VPN_W-1:0] pt_upd_vpn;
  logic acc_req, acc_hold; logic [VPN_W-1:0] acc_vpn;
  logic rsp_valid, rsp_ok; logic [VPN_W-1:0] rsp_vpn;

  spm_top #(.NUM_MOD(NUM_MOD), .MOD_W(MOD_W), .VPN_W(VPN_W), .PPN_W(PPN_W),
            .CNT_W(CNT_W), .PAGE_WORDS(PW), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_move(cmd_move),
    .cmd_mod(cmd_mod), .cmd_vpn(cmd_vpn), .cmd_npages(cmd_npages), .busy(busy),
    .alloc_req(alloc_req), .alloc_mod(alloc_mod), .alloc_npages(alloc_npages),
    .alloc_done(alloc_req), .alloc_ok(b_ok), .alloc_src_ppn(b_src),
    .alloc_dst_ppn(b_dst), .alloc_dst_vpn(b_dvpn), .inv_valid(inv_valid),
    .inv_vpn(inv_vpn), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .free_valid(free_valid), .free_ppn(free_ppn),
    .pt_upd_valid(pt_upd_valid), .pt_upd_vpn(pt_upd_vpn), .pt_upd_ppn(pt_upd_ppn),
    .acc_req(acc_req), .acc_vpn(acc_vpn), .acc_hold(acc_hold),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_vpn(rsp_vpn));

  // shared memory model, one-cycle read latency
  logic [DATA_W-1:0] mem [MEMSZ];
  logic mem_init;
  function automatic logic [DATA_W-1:0] pat(input int a);
    return DATA_W'(a * 37 + 5);
  endfunction
  always @(posedge clk) begin
    if (mem_init) begin
      for (int i = 0; i < MEMSZ; i++) mem[i] <= pat(i);
    end else begin
      if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
      if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit good, input string req, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int rr = 1;

  task automatic run(input bit mv, input int md, input int vpn, input int n,
                     input bit ok, input int src, input int dst, input int dvpn,
                     input bit poke, input bit probe, input int pvpn, input bit exp_hold);
    int j, exp_j, exp_mod, a_cnt, i_cnt, w_cnt, f_cnt, seen_mod, hold_seen;
    bit early, alloc_used;
    @(negedge clk); mem_init = 1'b1;
    @(negedge clk); mem_init = 1'b0;
    b_ok = ok; b_src = PPN_W'(src); b_dst = PPN_W'(dst); b_dvpn = VPN_W'(dvpn);
    alloc_used = (n != 0);
    exp_mod = md;
    if (md == 0 && alloc_used) begin
      exp_mod = rr; rr = (rr == NUM_MOD) ? 1 : rr + 1;
    end
    if (n == 0) exp_j = 1;
    else if (!ok) exp_j = 2;
    else exp_j = 2 + 2 * n * PW + (mv ? 2 * n : 0);
    cmd_valid = 1'b1; cmd_move = mv; cmd_mod = MOD_W'(md);
    cmd_vpn = VPN_W'(vpn); cmd_npages = CNT_W'(n);
    @(negedge clk); cmd_valid = 1'b0;
    j = 1; a_cnt = 0; i_cnt = 0; w_cnt = 0; f_cnt = 0; seen_mod = -1; hold_seen = -1;
    early = 1'b0;
    while (!rsp_valid && j < 400) begin
      if (alloc_req) begin a_cnt++; seen_mod = int'(alloc_mod);
        chk(alloc_npages == CNT_W'(n), "R2 alloc count", int'(alloc_npages), n); end
      if (inv_valid) begin
        chk(inv_vpn == VPN_W'(vpn + i_cnt), "R4 invalidate page", int'(inv_vpn), vpn + i_cnt);
        i_cnt++;
      end
      if (mem_wr_en) begin
        if (mv && i_cnt != n) early = 1'b1;
        w_cnt++;
      end
      if (free_valid || pt_upd_valid) begin
        chk(free_valid && pt_upd_valid && free_ppn == PPN_W'(src + f_cnt) &&
            pt_upd_vpn == VPN_W'(vpn + f_cnt) && pt_upd_ppn == PPN_W'(dst + f_cnt),
            "R6 release/rewrite", int'(pt_upd_ppn), dst + f_cnt);
        f_cnt++;
      end
      if (j == 4 && probe) hold_seen = int'(acc_hold);
      if (j == 3) begin
        if (poke) begin cmd_valid = 1'b1; cmd_move = ~mv; cmd_mod = 2'd1;
          cmd_vpn = 6'd50; cmd_npages = 3'd1; end
        if (probe) begin acc_req = 1'b1; acc_vpn = VPN_W'(pvpn); end
      end
      if (j == 4) begin cmd_valid = 1'b0; acc_req = 1'b0; end
      @(negedge clk); j++;
    end
    chk(j == exp_j, "R12 response edge", j, exp_j);
    chk(rsp_ok == (ok && n != 0), "R8/R11 rsp_ok", int'(rsp_ok), int'(ok && n != 0));
    chk(rsp_vpn == VPN_W'((ok && n != 0) ? (mv ? vpn : dvpn) : 0), "R6/R7 rsp_vpn",
        int'(rsp_vpn), (ok && n != 0) ? (mv ? vpn : dvpn) : 0);
    chk(a_cnt == (alloc_used ? 1 : 0), "R9/R11 allocation count", a_cnt, alloc_used ? 1 : 0);
    if (alloc_used) chk(seen_mod == exp_mod, "R2/R3 module", seen_mod, exp_mod);
    chk(i_cnt == ((mv && ok && n != 0) ? n : 0), "R4/R7/R8 invalidates", i_cnt,
        (mv && ok && n != 0) ? n : 0);
    chk(f_cnt == ((mv && ok && n != 0) ? n : 0), "R6/R7 releases", f_cnt,
        (mv && ok && n != 0) ? n : 0);
    chk(w_cnt == ((ok && n != 0) ? n * PW : 0), "R5/R8 write count", w_cnt,
        (ok && n != 0) ? n * PW : 0);
    chk(!early, "R4 write before last invalidate", int'(early), 0);
    if (probe) chk(hold_seen == int'(exp_hold), "R10 hold", hold_seen, int'(exp_hold));
    @(negedge clk);
    chk(!busy && !rsp_valid, "R9 idle after response", int'(busy), 0);
    for (int p = 0; p < 3; p++) begin
      for (int w = 0; w < PW; w++) begin
        int da, sa, e;
        da = (dst + p) * PW + w; sa = (src + p) * PW + w;
        e = (ok && p < n) ? int'(pat(sa)) : int'(pat(da));
        chk(mem[da] == DATA_W'(e), "R5 destination word", int'(mem[da]), e);
      end
    end
  endtask

  initial begin
    cmd_valid = 0; cmd_move = 0; cmd_mod = 0; cmd_vpn = 0; cmd_npages = 0;
    b_ok = 0; b_src = 0; b_dst = 0; b_dvpn = 0; acc_req = 0; acc_vpn = 0; mem_init = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !alloc_req && !inv_valid && !mem_rd_en && !mem_wr_en && !free_valid &&
        !pt_upd_valid && !rsp_valid, "R1 reset outputs", int'(busy), 0);
    rst_n = 1'b1;
    // explicit duplicate, one page (R2, R5, R7)
    run(0, 2, 5, 1, 1, 1, 8, 40, 0, 0, 0, 0);
    // sweep of operation and count with automatic choice (R3, R4, R5, R6, R7, R12)
    for (int n = 1; n <= 3; n++)
      for (int mv = 0; mv < 2; mv++)
        run(mv[0], 0, 10 + n, n, 1, 1, 8, 30 + n, 0, 0, 0, 0);
    // explicit module does not advance the rotation (R3)
    run(1, 3, 20, 2, 1, 2, 9, 0, 0, 0, 0, 0);
    run(0, 0, 21, 1, 1, 2, 9, 33, 0, 0, 0, 0);
    // relocate with a command poked while busy and a held access (R9, R10)
    run(1, 0, 16, 3, 1, 1, 8, 0, 1, 1, 17, 1);
    // access outside the run is not held (R10)
    run(1, 0, 16, 2, 1, 1, 8, 0, 0, 1, 18, 0);
    // duplicate never holds (R10)
    run(0, 0, 16, 2, 1, 1, 8, 44, 0, 1, 16, 0);
    // failed allocation (R8)
    run(1, 0, 12, 2, 0, 1, 8, 0, 0, 0, 0, 0);
    // zero count (R11)
    run(0, 0, 12, 0, 1, 1, 8, 7, 0, 0, 0, 0);
    run(0, 0, 22, 1, 1, 3, 10, 9, 0, 0, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule